// File: doc/BRIEF.md
# Per-thread fetch status controller

This block keeps, for each hardware thread of a multithreaded fetch unit, the thread's fetch status and a set of sticky stall flags, one per downstream pipeline stage. Each cycle it takes four kinds of input for every thread. The first is block and unblock pulses from the stages. The second is squash requests from commit and from decode. The third is a commit-side flag saying that the reorder buffer is still squashing. The fourth is instruction-memory events: a request sent and either accepted or refused, a retry granted, and a response returned. It also takes one global context-switch stall that applies to every thread. From these it computes each thread's next status.

For each thread the conditions are resolved in a fixed order. A squash from commit comes first. The reorder-buffer hold comes second. A squash from decode comes third, and it is ignored when the thread is already squashing. A stall that forces Blocked comes fourth, and it is skipped while the thread waits on memory. The automatic return to Running comes last. Memory events are used only when none of these conditions applies.

The block also flags any cycle in which some thread's status changes, and drives a stage-active output for the fetch stage. It tracks one abandoned memory request per thread, so that a response that arrives late is discarded.

Top module: `fsc_status_ctrl`

## Requirements
- R1: After reset every thread is Running, every stall flag is clear and every drop flag is clear. Status codes on `state_o` (4 bits per thread, thread t at bits 4t+3..4t) are: Running=0, Idle=1, Squashing=2, Blocked=3, TrapWait=4, QuiesceWait=5, MemWait=6, MemRetry=7, MemDone=8.
- R2: Each thread has one sticky stall flag per stage, addressed by input bit t*NUM_STAGES+s. A block pulse sets the flag and an unblock pulse clears it. The flag holds its value between pulses.
- R3: A commit squash for a thread puts that thread in Squashing on the next cycle, whatever else is asserted.
- R4: While the reorder-buffer-squashing input is high and no commit squash is present, the thread is Squashing on the next cycle, even when a stall is set.
- R5: A decode squash moves a thread that is not Squashing to Squashing. A decode squash that arrives while the thread is already Squashing has no effect.
- R6: If any stall flag of the thread is set (after this cycle's pulses are applied), or the global context stall is high, the thread goes to Blocked. A thread in MemWait or MemRetry keeps its state instead.
- R7: A thread in Blocked or Squashing with no squash, no hold and no stall that cycle returns to Running.
- R8: From Running, a request that is accepted leads to MemWait and a request that is refused leads to MemRetry. From MemRetry, a retry grant leads to MemWait.
- R9: A live response in MemWait leads to Blocked if a stall is present, and to MemDone otherwise. MemDone returns to Running on the following cycle.
- R10: When a thread leaves MemWait for Squashing with its request still outstanding, `drop_resp_o` for that thread rises. The next response for that thread clears the flag and changes no state.
- R11: `status_changed_o` is high in exactly those cycles in which some thread's status will change at the coming clock edge.
- R12: `stage_active_o` is high when at least one thread marked active is in Running, Squashing or MemDone.
- R13: Each thread's inputs affect only that thread's state. The only exception is the global context stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active_i | input | NUM_THREADS | Threads counted for stage activity |
| blk_pulse_i | input | NUM_THREADS*NUM_STAGES | Block pulses, bit t*NUM_STAGES+s |
| unblk_pulse_i | input | NUM_THREADS*NUM_STAGES | Unblock pulses, same indexing |
| cmt_squash_i | input | NUM_THREADS | Squash request from commit |
| rob_squashing_i | input | NUM_THREADS | Reorder buffer still squashing |
| dec_squash_i | input | NUM_THREADS | Squash request from decode |
| ctx_stall_i | input | 1 | Global context-switch stall |
| mem_req_i | input | NUM_THREADS | Memory request issued this cycle |
| mem_accept_i | input | NUM_THREADS | Issued request was accepted |
| mem_retry_i | input | NUM_THREADS | Refused request re-sent and accepted |
| mem_resp_i | input | NUM_THREADS | Memory response for the thread |
| state_o | output | NUM_THREADS*4 | Current status per thread |
| drop_resp_o | output | NUM_THREADS | Next response will be discarded |
| status_changed_o | output | 1 | Some thread changes status at the coming edge |
| stage_active_o | output | 1 | Stage has an active, fetch-capable thread |

## Verification
The assertions assume that a stage never sends block and unblock in the same cycle. They also assume that an unblock is sent only while the matching flag is set. Both assumptions are checked as assumptions on the stimulus. The bench's directed tasks send an unblock only after a block for that same stage and thread, and each pulse lasts one cycle. The bench keeps at most one abandoned memory request per thread outstanding. It returns a response only for a request it has issued, and it sends the stale response before the live one.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
   localparam int STATE_W = 4;

   typedef enum logic [STATE_W-1:0] {
      ST_RUN          = 4'd0,
      ST_IDLE         = 4'd1,
      ST_SQUASH       = 4'd2,
      ST_BLOCKED      = 4'd3,
      ST_TRAP_WAIT    = 4'd4,
      ST_QUIESCE_WAIT = 4'd5,
      ST_MEM_WAIT     = 4'd6,
      ST_MEM_RETRY    = 4'd7,
      ST_MEM_DONE     = 4'd8
   } fetch_state_e;
endpackage

// File: rtl/fsc_stall_bits.sv
module fsc_stall_bits #(
   parameter int NUM_STAGES = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_STAGES-1:0] blk_i,
   input  logic [NUM_STAGES-1:0] unblk_i,
   output logic [NUM_STAGES-1:0] bits_q,
   output logic                  any_nxt_o
);
   logic [NUM_STAGES-1:0] bits_nxt;

   // set wins over clear; both together is a protocol violation
   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_bit
      assign bits_nxt[s] = blk_i[s] ? 1'b1 : (unblk_i[s] ? 1'b0 : bits_q[s]);
   end

   assign any_nxt_o = |bits_nxt;

   always_ff @(posedge clk) begin
      if (!rst_n) bits_q <= '0;
      else        bits_q <= bits_nxt;
   end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
   import fsc_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cmt_squash_i,
   input  logic         rob_hold_i,
   input  logic         dec_squash_i,
   input  logic         stall_i,
   input  logic         req_i,
   input  logic         accept_i,
   input  logic         retry_i,
   input  logic         resp_i,
   output fetch_state_e state_q,
   output fetch_state_e state_nxt,
   output logic         drop_q
);
   logic drop_nxt;
   logic live_resp;
   logic in_mem;

   assign live_resp = resp_i && !drop_q;
   assign in_mem    = (state_q == ST_MEM_WAIT) || (state_q == ST_MEM_RETRY);

   always_comb begin
      state_nxt = state_q;
      if (cmt_squash_i) begin
         state_nxt = ST_SQUASH;
      end else if (rob_hold_i) begin
         state_nxt = ST_SQUASH;
      end else if (dec_squash_i && state_q != ST_SQUASH) begin
         state_nxt = ST_SQUASH;
      end else if (stall_i && !in_mem) begin
         state_nxt = ST_BLOCKED;
      end else if (state_q == ST_BLOCKED || state_q == ST_SQUASH) begin
         state_nxt = ST_RUN;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (req_i) state_nxt = accept_i ? ST_MEM_WAIT : ST_MEM_RETRY;
            end
            ST_MEM_RETRY: begin
               if (retry_i) state_nxt = ST_MEM_WAIT;
            end
            ST_MEM_WAIT: begin
               if (live_resp) state_nxt = stall_i ? ST_BLOCKED : ST_MEM_DONE;
            end
            ST_MEM_DONE: state_nxt = ST_RUN;
            default:     state_nxt = state_q;
         endcase
      end
   end

   // one abandoned request remembered; the stale response is consumed first
   assign drop_nxt = (drop_q && !resp_i) ||
                     (state_q == ST_MEM_WAIT && state_nxt == ST_SQUASH && !live_resp);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_RUN;
         drop_q  <= 1'b0;
      end else begin
         state_q <= state_nxt;
         drop_q  <= drop_nxt;
      end
   end
endmodule

// File: rtl/fsc_status_ctrl.sv
module fsc_status_ctrl
   import fsc_pkg::*;
#(
   parameter int NUM_THREADS = 2,
   parameter int NUM_STAGES  = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_THREADS-1:0]            thread_active_i,
   input  logic [NUM_THREADS*NUM_STAGES-1:0] blk_pulse_i,
   input  logic [NUM_THREADS*NUM_STAGES-1:0] unblk_pulse_i,
   input  logic [NUM_THREADS-1:0]            cmt_squash_i,
   input  logic [NUM_THREADS-1:0]            rob_squashing_i,
   input  logic [NUM_THREADS-1:0]            dec_squash_i,
   input  logic                              ctx_stall_i,
   input  logic [NUM_THREADS-1:0]            mem_req_i,
   input  logic [NUM_THREADS-1:0]            mem_accept_i,
   input  logic [NUM_THREADS-1:0]            mem_retry_i,
   input  logic [NUM_THREADS-1:0]            mem_resp_i,
   output logic [NUM_THREADS*STATE_W-1:0]    state_o,
   output logic [NUM_THREADS-1:0]            drop_resp_o,
   output logic                              status_changed_o,
   output logic                              stage_active_o
);
   localparam int FLAG_W = NUM_THREADS * NUM_STAGES;

   if (NUM_THREADS < 1) begin : g_bad_threads
      $error("NUM_THREADS must be at least 1");
   end
   if (NUM_STAGES < 1) begin : g_bad_stages
      $error("NUM_STAGES must be at least 1");
   end

   logic [FLAG_W-1:0]      stall_flat;
   logic [NUM_THREADS-1:0] stall_any;
   logic [NUM_THREADS-1:0] moving;
   logic [NUM_THREADS-1:0] fetch_ready;

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      fetch_state_e cur_st;
      fetch_state_e nxt_st;
      logic         any_stage;

      fsc_stall_bits #(.NUM_STAGES(NUM_STAGES)) u_bits (
         .clk       (clk),
         .rst_n     (rst_n),
         .blk_i     (blk_pulse_i[t*NUM_STAGES +: NUM_STAGES]),
         .unblk_i   (unblk_pulse_i[t*NUM_STAGES +: NUM_STAGES]),
         .bits_q    (stall_flat[t*NUM_STAGES +: NUM_STAGES]),
         .any_nxt_o (any_stage)
      );

      assign stall_any[t] = any_stage || ctx_stall_i;

      fsc_thread_fsm u_fsm (
         .clk          (clk),
         .rst_n        (rst_n),
         .cmt_squash_i (cmt_squash_i[t]),
         .rob_hold_i   (rob_squashing_i[t]),
         .dec_squash_i (dec_squash_i[t]),
         .stall_i      (stall_any[t]),
         .req_i        (mem_req_i[t]),
         .accept_i     (mem_accept_i[t]),
         .retry_i      (mem_retry_i[t]),
         .resp_i       (mem_resp_i[t]),
         .state_q      (cur_st),
         .state_nxt    (nxt_st),
         .drop_q       (drop_resp_o[t])
      );

      assign state_o[t*STATE_W +: STATE_W] = cur_st;
      assign moving[t]      = (nxt_st != cur_st);
      assign fetch_ready[t] = thread_active_i[t] &&
                              (cur_st == ST_RUN || cur_st == ST_SQUASH ||
                               cur_st == ST_MEM_DONE);
   end

   assign status_changed_o = |moving;
   assign stage_active_o   = |fetch_ready;
endmodule

// File: rtl/fsc_status_ctrl_chk.sv
module fsc_status_ctrl_chk
   import fsc_pkg::*;
#(
   parameter int NUM_THREADS = 2,
   parameter int NUM_STAGES  = 4
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [NUM_THREADS*NUM_STAGES-1:0] blk_pulse_i,
   input logic [NUM_THREADS*NUM_STAGES-1:0] unblk_pulse_i,
   input logic [NUM_THREADS*NUM_STAGES-1:0] stall_flat,
   input logic [NUM_THREADS-1:0]            cmt_squash_i,
   input logic [NUM_THREADS-1:0]            rob_squashing_i,
   input logic [NUM_THREADS-1:0]            dec_squash_i,
   input logic [NUM_THREADS-1:0]            mem_resp_i,
   input logic [NUM_THREADS*STATE_W-1:0]    state_o,
   input logic [NUM_THREADS-1:0]            drop_resp_o,
   input logic                              status_changed_o
);
   AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_pulse_i & unblk_pulse_i) == '0); // R2
   AST_UNBLOCK_WHEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (unblk_pulse_i & ~stall_flat) == '0); // R2
   AST_CHANGE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      status_changed_o |=> state_o != $past(state_o)); // R11

   for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic [STATE_W-1:0] st;
      assign st = state_o[t*STATE_W +: STATE_W];

      AST_COMMIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         cmt_squash_i[t] |=> st == 4'(ST_SQUASH)); // R3
      AST_ROB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         rob_squashing_i[t] |=> st == 4'(ST_SQUASH)); // R4
      AST_WAIT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (st == 4'(ST_MEM_WAIT) && !cmt_squash_i[t] && !rob_squashing_i[t] &&
          !dec_squash_i[t] && !mem_resp_i[t]) |=> st == 4'(ST_MEM_WAIT)); // R6
      AST_DONE_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
         st == 4'(ST_MEM_DONE) |=> st != 4'(ST_MEM_DONE)); // R9
      AST_DROP_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
         (st == 4'(ST_MEM_WAIT) && cmt_squash_i[t] && !mem_resp_i[t]) |=> drop_resp_o[t]); // R10
   end
endmodule

bind fsc_status_ctrl fsc_status_ctrl_chk #(
   .NUM_THREADS(NUM_THREADS),
   .NUM_STAGES (NUM_STAGES)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .blk_pulse_i      (blk_pulse_i),
   .unblk_pulse_i    (unblk_pulse_i),
   .stall_flat       (stall_flat),
   .cmt_squash_i     (cmt_squash_i),
   .rob_squashing_i  (rob_squashing_i),
   .dec_squash_i     (dec_squash_i),
   .mem_resp_i       (mem_resp_i),
   .state_o          (state_o),
   .drop_resp_o      (drop_resp_o),
   .status_changed_o (status_changed_o)
);

// File: tb/fsc_status_ctrl_bench.sv
module fsc_status_ctrl_bench;
   localparam int NT = 2;
   localparam int NS = 4;
   localparam logic [3:0] S_RUN = 4'd0, S_SQ = 4'd2, S_BLK = 4'd3,
                          S_WAIT = 4'd6, S_RETRY = 4'd7, S_DONE = 4'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NT-1:0]    act;
   logic [NT*NS-1:0] blk, unblk;
   logic [NT-1:0]    cmt, rob, dec, req, acc, rty, rsp;
   logic             ctx;
   logic [NT*4-1:0]  st;
   logic [NT-1:0]    drop;
   logic             chg, sact;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   fsc_status_ctrl #(.NUM_THREADS(NT), .NUM_STAGES(NS)) u_fsc_status_ctrl (
      .clk(clk), .rst_n(rst_n), .thread_active_i(act),
      .blk_pulse_i(blk), .unblk_pulse_i(unblk),
      .cmt_squash_i(cmt), .rob_squashing_i(rob), .dec_squash_i(dec),
      .ctx_stall_i(ctx), .mem_req_i(req), .mem_accept_i(acc),
      .mem_retry_i(rty), .mem_resp_i(rsp),
      .state_o(st), .drop_resp_o(drop),
      .status_changed_o(chg), .stage_active_o(sact)
   );

   task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
      checks++;
      if (actual !== expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   function automatic logic [3:0] thr(input int t);
      return st[t*4 +: 4];
   endfunction

   task automatic clr();
      blk = '0; unblk = '0; cmt = '0; rob = '0; dec = '0;
      req = '0; acc = '0; rty = '0; rsp = '0; ctx = 1'b0;
      act = '1;
   endtask

   // inputs are set mid-cycle; one edge; outputs read 1 ns after it
   task automatic step();
      @(posedge clk);
      #1;
      clr();
   endtask

   task automatic t_reset();
      clr();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      #2;
      chk("R1 thread0 state", thr(0), S_RUN);
      chk("R1 thread1 state", thr(1), S_RUN);
      chk("R1 drop flags", drop, 0);
      chk("R11 no change when idle", chg, 0);
      chk("R12 active after reset", sact, 1);
      act = '0; #1;
      chk("R12 no active thread", sact, 0);
      act = '1;
   endtask

   task automatic t_stall();
      blk[0*NS+2] = 1'b1;
      step();
      chk("R2 block sets stall", thr(0), S_BLK);
      chk("R13 other thread untouched", thr(1), S_RUN);
      chk("R11 blocked and stalled is stable", chg, 0);
      step();
      chk("R2 stall sticky", thr(0), S_BLK);
      unblk[0*NS+2] = 1'b1; #1;
      chk("R11 change pending", chg, 1);
      step();
      chk("R7 blocked to running", thr(0), S_RUN);
      ctx = 1'b1;
      step();
      chk("R6 ctx stall thread0", thr(0), S_BLK);
      chk("R6 ctx stall thread1", thr(1), S_BLK);
      chk("R12 all blocked inactive", sact, 0);
      step();
      chk("R7 thread1 resumes", thr(1), S_RUN);
   endtask

   task automatic t_squash();
      cmt[0] = 1'b1; blk[0*NS+0] = 1'b1;
      step();
      chk("R3 commit squash beats stall", thr(0), S_SQ);
      unblk[0*NS+0] = 1'b1;
      step();
      chk("R7 squashing to running", thr(0), S_RUN);
      cmt[1] = 1'b1;
      step();
      rob[1] = 1'b1; blk[1*NS+3] = 1'b1;
      step();
      chk("R4 rob hold beats stall", thr(1), S_SQ);
      rob[1] = 1'b1;
      step();
      chk("R4 rob hold continues", thr(1), S_SQ);
      unblk[1*NS+3] = 1'b1;
      step();
      chk("R7 after hold", thr(1), S_RUN);
      dec[0] = 1'b1;
      step();
      chk("R5 decode squash", thr(0), S_SQ);
      dec[0] = 1'b1;
      step();
      chk("R5 decode squash ignored while squashing", thr(0), S_RUN);
   endtask

   task automatic t_cache();
      req[0] = 1'b1; acc[0] = 1'b1;
      step();
      chk("R8 accepted request", thr(0), S_WAIT);
      blk[0*NS+1] = 1'b1;
      step();
      chk("R6 wait holds under stall", thr(0), S_WAIT);
      rsp[0] = 1'b1;
      step();
      chk("R9 response with stall", thr(0), S_BLK);
      unblk[0*NS+1] = 1'b1;
      step();
      chk("R7 unblocked", thr(0), S_RUN);
      req[1] = 1'b1;
      step();
      chk("R8 refused request", thr(1), S_RETRY);
      ctx = 1'b1;
      step();
      chk("R6 retry holds under stall", thr(1), S_RETRY);
      rty[1] = 1'b1;
      step();
      chk("R8 retry granted", thr(1), S_WAIT);
      rsp[1] = 1'b1;
      step();
      chk("R9 response to done", thr(1), S_DONE);
      act = 2'b10; #1;
      chk("R12 done counts active", sact, 1);
      step();
      chk("R9 done to running", thr(1), S_RUN);
   endtask

   task automatic t_drop();
      req[0] = 1'b1; acc[0] = 1'b1;
      step();
      cmt[0] = 1'b1;
      step();
      chk("R3 squash in wait", thr(0), S_SQ);
      chk("R10 drop raised", drop[0], 1);
      step();
      chk("R10 drop kept", drop[0], 1);
      req[0] = 1'b1; acc[0] = 1'b1;
      step();
      chk("R8 reissue", thr(0), S_WAIT);
      rsp[0] = 1'b1;
      step();
      chk("R10 stale response ignored", thr(0), S_WAIT);
      chk("R10 drop cleared", drop[0], 0);
      rsp[0] = 1'b1;
      step();
      chk("R9 live response", thr(0), S_DONE);
      step();
      chk("R9 back to running", thr(0), S_RUN);
   endtask

   initial begin
      t_reset();
      t_stall();
      t_squash();
      t_cache();
      t_drop();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule